// File: doc/BRIEF.md
# Directional Tile Switch Box

This block is the configurable interconnect of one logic tile in a mesh fabric. Each of the four directions (north, east, south, west) has a bus of tile-input wires. These wires gather signals from the outgoing buses of tiles up to `SPAN` steps away along that direction. The block also drives four outgoing buses, one per direction. Every LUT input and every slice clock inside the tile is fed by its own selector. The logic slices and the pads sit outside the block. They hand their outputs in on `slice_out`, and they take `lut_in` and `slice_clk` back.

Tile-input selectors are deliberately sparse. A tile-input wire with index n can take a neighbour's outgoing wire m only when bit n of a fixed 16-bit pattern for m is set. The patterns for m = 0..7 are 0xAAAA, 0x5555, 0x6666, 0x9999, 0x3333, 0xCCCC, 0xF0F0 and 0x0F0F, so every input index sees exactly four of the eight outgoing indices at each distance. The local selectors (tile outputs, LUT inputs, clocks) are full crossbars over their own candidate lists.

Every selector holds a `SEL_W`-bit code. The codes travel over a serial configuration chain. Software shifts the whole image in while `cfg_en` is high, and all selectors switch together once `cfg_en` is seen low again. The tile's grid position and the grid size are parameters, so a candidate that lies beyond the fabric edge is a constant 0.

Top module: `swb_tile`

## Requirements
- R1: After reset every selector holds the all-ones code, so `tile_out`, `lut_in` and `slice_clk` are all 0 whatever `nbr_bus` and `slice_out` carry.
- R2: While `cfg_en` is high, one bit of `cfg_din` shifts in on each clock and the outputs keep following the previous image. The image shifted in replaces all selector codes at the first clock edge at which `cfg_en` is low after having been high. The last bit shifted in becomes bit 0 of the image. The image layout, with field f at bits [f*SEL_W +: SEL_W], is as follows: fields 0..4*IN_W-1 are the tile inputs, numbered d*IN_W+n. The next 4*OUT_W fields are the tile outputs, numbered d*OUT_W+i. The next SLICES*LUT_K fields are the LUT inputs, numbered s*LUT_K+k. The last SLICES fields are the clocks. Directions are encoded N=0, E=1, S=2, W=3.
- R3: For tile input (d, n), let C be the number of patterns whose bit n is set. Code k < SPAN*C selects step s = k/C + 1 and outgoing index m, where m is the (k mod C)-th such pattern in ascending order of m. That candidate is `nbr_bus[(d*SPAN + s-1)*OUT_W + m]`.
- R4: A candidate whose source tile lies outside the grid reads 0. The source tile is at (TILE_X, TILE_Y-s) for N, (TILE_X+s, TILE_Y) for E, (TILE_X, TILE_Y+s) for S and (TILE_X-s, TILE_Y) for W.
- R5: Any code at or above a selector's candidate count, the all-ones code included, drives 0.
- R6: For a tile output, code c < SLICES selects `slice_out[c]`, and code SLICES+t selects tile input t (t = d*IN_W+n).
- R7: LUT inputs use the same code map as tile outputs.
- R8: For a slice clock, code t < 4*IN_W selects tile input t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable; falling edge commits the image |
| cfg_din | input | 1 | Serial configuration data |
| nbr_bus | input | 4*SPAN*OUT_W | Outgoing buses of the neighbours at steps 1..SPAN in each direction |
| slice_out | input | SLICES | Local slice outputs |
| tile_out | output | 4*OUT_W | Outgoing directional buses, index d*OUT_W+i |
| lut_in | output | SLICES*LUT_K | LUT input wires, index s*LUT_K+k |
| slice_clk | output | SLICES | Per-slice clock selections |

## Verification
The tile is placed one step in from the north-west corner, so north and west have only a single in-fabric step while east and south have four. Every tile-input code from 0 to 15, plus two illegal codes, is swept with a walking one and a walking zero across all of `nbr_bus`. The tile inputs are routed out through tile outputs and LUT inputs. The walking one separates the step, the pattern rank and the edge masking for each direction. The walking zero exposes any selector that picks more than one source. The slice-output codes are swept with a walking one on `slice_out`. Mixed local codes are then tried under pseudo-random neighbour data. A partial image shifted in over a live configuration shows whether outputs change before the commit.

// File: rtl/swb_pkg.sv
package swb_pkg;

  localparam int NUM_DIRS     = 4;
  localparam int NUM_PATTERNS = 8;
  localparam int DIR_N = 0;
  localparam int DIR_E = 1;
  localparam int DIR_S = 2;
  localparam int DIR_W = 3;

  // Which tile-input indices may take outgoing index m of a neighbour.
  function automatic logic [15:0] span_pattern(input int m);
    case (m)
      0: return 16'hAAAA;
      1: return 16'h5555;
      2: return 16'h6666;
      3: return 16'h9999;
      4: return 16'h3333;
      5: return 16'hCCCC;
      6: return 16'hF0F0;
      7: return 16'h0F0F;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int cand_count(input int n, input int out_w);
    int c;
    logic [15:0] p;
    c = 0;
    for (int m = 0; m < out_w && m < NUM_PATTERNS; m++) begin
      p = span_pattern(m);
      if (p[n]) c++;
    end
    return c;
  endfunction

  // Outgoing index of the j-th candidate (ascending m) for input index n.
  function automatic int cand_pick(input int n, input int j, input int out_w);
    int seen;
    int r;
    logic [15:0] p;
    seen = 0;
    r = 0;
    for (int m = 0; m < out_w && m < NUM_PATTERNS; m++) begin
      p = span_pattern(m);
      if (p[n]) begin
        if (seen == j) r = m;
        seen++;
      end
    end
    return r;
  endfunction

  function automatic bit nbr_inside(input int d, input int s, input int tx, input int ty,
                                    input int gw, input int gh);
    case (d)
      DIR_N:   return (ty - s) >= 0;
      DIR_E:   return (tx + s) < gw;
      DIR_S:   return (ty + s) < gh;
      default: return (tx - s) >= 0;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swb_sel_mux.sv
module swb_sel_mux #(
  parameter int N  = 8,
  parameter int SW = 4
) (
  input  logic [N-1:0]  cand,
  input  logic [SW-1:0] sel,
  output logic          y
);
  // Codes at or above N leave the wire undriven (0).
  always_comb begin
    y = 1'b0;
    for (int i = 0; i < N; i++)
      if (sel == SW'(i)) y = cand[i];
  end
endmodule

// File: rtl/swb_cfg_chain.sv
module swb_cfg_chain #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic [W-1:0] word
);
  logic [W-1:0] shreg;
  logic         en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      en_q  <= 1'b0;
      word  <= '1;
    end else begin
      en_q <= cfg_en;
      if (cfg_en) shreg <= {shreg[W-2:0], cfg_din};
      if (en_q && !cfg_en) word <= shreg;
    end
  end
endmodule

// File: rtl/swb_tile.sv
module swb_tile
  import swb_pkg::*;
#(
  parameter int IN_W   = 10,
  parameter int OUT_W  = 8,
  parameter int SLICES = 8,
  parameter int LUT_K  = 4,
  parameter int SPAN   = 4,
  parameter int GRID_W = 8,
  parameter int GRID_H = 8,
  parameter int TILE_X = 1,
  parameter int TILE_Y = 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_en,
  input  logic                             cfg_din,
  input  logic [NUM_DIRS*SPAN*OUT_W-1:0]   nbr_bus,
  input  logic [SLICES-1:0]                slice_out,
  output logic [NUM_DIRS*OUT_W-1:0]        tile_out,
  output logic [SLICES*LUT_K-1:0]          lut_in,
  output logic [SLICES-1:0]                slice_clk
);
  localparam int TIN_N    = NUM_DIRS * IN_W;
  localparam int TOUT_N   = NUM_DIRS * OUT_W;
  localparam int LUT_N    = SLICES * LUT_K;
  localparam int LOC_N    = SLICES + TIN_N;
  localparam int TIN_CAND = SPAN * OUT_W;
  localparam int SEL_W    = $clog2(max2(LOC_N, TIN_CAND) + 1);
  localparam int TO_OFF   = TIN_N;
  localparam int LU_OFF   = TO_OFF + TOUT_N;
  localparam int CK_OFF   = LU_OFF + LUT_N;
  localparam int FIELDS   = CK_OFF + SLICES;
  localparam int CFG_W    = FIELDS * SEL_W;

  logic [CFG_W-1:0] cfg_word;
  logic [TIN_N-1:0] tin;
  logic [LOC_N-1:0] loc_src;

  swb_cfg_chain #(.W(CFG_W)) u_chain (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .word(cfg_word)
  );

  // Sparse tile-input selectors: candidates ordered by step, then pattern rank.
  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    for (genvar n = 0; n < IN_W; n++) begin : g_in
      localparam int CNT = cand_count(n, OUT_W);
      logic [TIN_CAND-1:0] cand;
      for (genvar p = 0; p < TIN_CAND; p++) begin : g_p
        if (p < SPAN * CNT) begin : g_live
          localparam int S  = p / CNT;
          localparam int M  = cand_pick(n, p % CNT, OUT_W);
          localparam bit OK = nbr_inside(d, S + 1, TILE_X, TILE_Y, GRID_W, GRID_H);
          assign cand[p] = nbr_bus[(d*SPAN + S)*OUT_W + M] & OK;
        end else begin : g_dead
          assign cand[p] = 1'b0;
        end
      end
      swb_sel_mux #(.N(TIN_CAND), .SW(SEL_W)) u_mux (
        .cand(cand),
        .sel (cfg_word[(d*IN_W + n)*SEL_W +: SEL_W]),
        .y   (tin[d*IN_W + n])
      );
    end
  end

  assign loc_src = {tin, slice_out};

  for (genvar o = 0; o < TOUT_N; o++) begin : g_tout
    swb_sel_mux #(.N(LOC_N), .SW(SEL_W)) u_mux (
      .cand(loc_src), .sel(cfg_word[(TO_OFF + o)*SEL_W +: SEL_W]), .y(tile_out[o])
    );
  end

  for (genvar l = 0; l < LUT_N; l++) begin : g_lut
    swb_sel_mux #(.N(LOC_N), .SW(SEL_W)) u_mux (
      .cand(loc_src), .sel(cfg_word[(LU_OFF + l)*SEL_W +: SEL_W]), .y(lut_in[l])
    );
  end

  for (genvar c = 0; c < SLICES; c++) begin : g_clk
    swb_sel_mux #(.N(TIN_N), .SW(SEL_W)) u_mux (
      .cand(tin), .sel(cfg_word[(CK_OFF + c)*SEL_W +: SEL_W]), .y(slice_clk[c])
    );
  end

endmodule

// File: rtl/swb_tile_chk.sv
module swb_tile_chk #(
  parameter int SEL_W  = 6,
  parameter int CFG_W  = 672,
  parameter int SLICES = 8,
  parameter int TOUT_N = 32,
  parameter int LUT_N  = 32,
  parameter int TO_OFF = 40,
  parameter int LU_OFF = 72,
  parameter int CK_OFF = 104
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic [CFG_W-1:0]  cfg_word,
  input logic [SLICES-1:0] slice_out,
  input logic [TOUT_N-1:0] tile_out,
  input logic [LUT_N-1:0]  lut_in,
  input logic [SLICES-1:0] slice_clk
);
  localparam int SIW = (SLICES > 1) ? $clog2(SLICES) : 1;

  logic [SEL_W-1:0] to0_sel, lu0_sel, ck0_sel;
  assign to0_sel = cfg_word[TO_OFF*SEL_W +: SEL_W];
  assign lu0_sel = cfg_word[LU_OFF*SEL_W +: SEL_W];
  assign ck0_sel = cfg_word[CK_OFF*SEL_W +: SEL_W];

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tile_out == '0 && lut_in == '0 && slice_clk == '0));

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(cfg_word));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !$past(cfg_en)) |=> $stable(cfg_word));

  // R6
  tout_slice_src_chk: assert property (@(posedge clk) disable iff (rst)
    (to0_sel < SEL_W'(SLICES)) |-> (tile_out[0] == slice_out[to0_sel[SIW-1:0]]));

  // R7
  lut_slice_src_chk: assert property (@(posedge clk) disable iff (rst)
    (lu0_sel < SEL_W'(SLICES)) |-> (lut_in[0] == slice_out[lu0_sel[SIW-1:0]]));

  // R5
  clk_undriven_chk: assert property (@(posedge clk) disable iff (rst)
    (ck0_sel == '1) |-> (slice_clk[0] == 1'b0));

endmodule

bind swb_tile swb_tile_chk #(
  .SEL_W(SEL_W), .CFG_W(CFG_W), .SLICES(SLICES), .TOUT_N(TOUT_N), .LUT_N(LUT_N),
  .TO_OFF(TO_OFF), .LU_OFF(LU_OFF), .CK_OFF(CK_OFF)
) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_word(cfg_word), .slice_out(slice_out),
  .tile_out(tile_out), .lut_in(lut_in), .slice_clk(slice_clk)
);

// File: tb/swb_tile_test.sv
module swb_tile_test;
  localparam int IN_W = 10, OUT_W = 8, SLICES = 8, LUT_K = 4, SPAN = 4;
  localparam int GW = 8, GH = 8, TX = 1, TY = 1;
  localparam int TIN_N = 4 * IN_W;
  localparam int TOUT_N = 4 * OUT_W;
  localparam int LUT_N = SLICES * LUT_K;
  localparam int SEL_W = 6;
  localparam int NF = TIN_N + TOUT_N + LUT_N + SLICES;
  localparam int CW = NF * SEL_W;
  localparam int NBW = 4 * SPAN * OUT_W;
  localparam int OW = TOUT_N + LUT_N + SLICES;
  localparam int TO_F = TIN_N, LU_F = TIN_N + TOUT_N, CK_F = TIN_N + TOUT_N + LUT_N;
  localparam logic [15:0] BPAT [8] = '{16'hAAAA, 16'h5555, 16'h6666, 16'h9999,
                                       16'h3333, 16'hCCCC, 16'hF0F0, 16'h0F0F};

  logic clk = 1'b0, rst = 1'b1, cfg_en = 1'b0, cfg_din = 1'b0;
  logic [NBW-1:0] nbr = '0;
  logic [SLICES-1:0] sl = '0;
  logic [TOUT_N-1:0] tile_out;
  logic [LUT_N-1:0] lut_in;
  logic [SLICES-1:0] slice_clk;
  logic [CW-1:0] cur = '1, nxt = '1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swb_tile #(.IN_W(IN_W), .OUT_W(OUT_W), .SLICES(SLICES), .LUT_K(LUT_K), .SPAN(SPAN),
             .GRID_W(GW), .GRID_H(GH), .TILE_X(TX), .TILE_Y(TY)) uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .nbr_bus(nbr),
    .slice_out(sl), .tile_out(tile_out), .lut_in(lut_in), .slice_clk(slice_clk)
  );

  function automatic int fld(int f);
    return int'(cur[f*SEL_W +: SEL_W]);
  endfunction

  // R3 R4 R5: tile-input value computed from the code map and grid position.
  function automatic logic tin_val(int t);
    int d, n, k, cnt, s, j, m, seen;
    bit ok;
    d = t / IN_W; n = t % IN_W; k = fld(t);
    cnt = 0; seen = 0; m = 0;
    for (int mm = 0; mm < 8; mm++) if (BPAT[mm][n]) cnt++;
    if (cnt == 0 || k >= SPAN * cnt) return 1'b0;
    s = k / cnt + 1; j = k % cnt;
    for (int mm = 0; mm < 8; mm++)
      if (BPAT[mm][n]) begin
        if (seen == j) m = mm;
        seen++;
      end
    case (d)
      0: ok = (TY - s) >= 0;
      1: ok = (TX + s) < GW;
      2: ok = (TY + s) < GH;
      default: ok = (TX - s) >= 0;
    endcase
    if (!ok) return 1'b0;
    return nbr[(d*SPAN + s - 1)*OUT_W + m];
  endfunction

  function automatic logic loc_val(int code);
    if (code < SLICES) return sl[code];
    if (code < SLICES + TIN_N) return tin_val(code - SLICES);
    return 1'b0;
  endfunction

  function automatic logic [OW-1:0] model();
    logic [TOUT_N-1:0] e_to;
    logic [LUT_N-1:0] e_lu;
    logic [SLICES-1:0] e_ck;
    int c;
    for (int i = 0; i < TOUT_N; i++) e_to[i] = loc_val(fld(TO_F + i));
    for (int i = 0; i < LUT_N; i++) e_lu[i] = loc_val(fld(LU_F + i));
    for (int i = 0; i < SLICES; i++) begin
      c = fld(CK_F + i);
      e_ck[i] = (c < TIN_N) ? tin_val(c) : 1'b0;
    end
    return {e_to, e_lu, e_ck};
  endfunction

  task automatic chk(input string tag);
    logic [OW-1:0] exp_v, act_v;
    #1;
    exp_v = model();
    act_v = {tile_out, lut_in, slice_clk};
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic setf(input int f, input int code);
    nxt[f*SEL_W +: SEL_W] = SEL_W'(code);
  endtask

  // R2: shift nxt in MSB first; optionally check outputs still follow cur.
  task automatic load(input bit midchk);
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_din = nxt[i];
      if (midchk && (i == CW / 2 || i == 0)) chk("R2 hold during shift");
    end
    @(negedge clk);
    cfg_en = 1'b0;
    @(negedge clk);
    cur = nxt;
  endtask

  task automatic route_tin_out();
    for (int f = 0; f < TOUT_N; f++) setf(TO_F + f, SLICES + f);
    for (int f = 0; f < TIN_N - TOUT_N; f++) setf(LU_F + f, SLICES + TOUT_N + f);
    for (int f = TIN_N - TOUT_N; f < LUT_N; f++) setf(LU_F + f, f % SLICES);
    for (int s = 0; s < SLICES; s++) setf(CK_F + s, s * 5);
  endtask

  initial begin
    nbr = '1; sl = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state, all undriven");
    nbr = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    chk("R1 reset state, mixed inputs");

    // Tile-input code sweep with walking one / zero over the neighbour bus.
    sl = '0;
    for (int k = 0; k < 18; k++) begin
      int code;
      code = (k < 16) ? k : ((k == 16) ? 20 : 63);
      nxt = '1;
      for (int t = 0; t < TIN_N; t++) setf(t, code);
      route_tin_out();
      load(1'b0);
      for (int b = 0; b < NBW; b++) begin
        nbr = NBW'(1) << b;
        chk((k < 16) ? "R3 R4 walking one" : "R5 illegal tile-input code");
        nbr = ~(NBW'(1) << b);
        chk((k < 16) ? "R3 R4 walking zero" : "R5 illegal tile-input code");
      end
    end

    // Slice-output codes for tile outputs and LUT inputs.
    nbr = '1;
    for (int c = 0; c < SLICES; c++) begin
      nxt = '1;
      for (int t = 0; t < TIN_N; t++) setf(t, 0);
      for (int f = 0; f < TOUT_N; f++) setf(TO_F + f, c);
      for (int f = 0; f < LUT_N; f++) setf(LU_F + f, c);
      load(1'b0);
      for (int b = 0; b < SLICES; b++) begin
        sl = SLICES'(1) << b;
        chk("R6 R7 slice source");
      end
      sl = '0; chk("R6 R7 slice source zero");
      sl = '1; chk("R6 R7 slice source ones");
    end

    // Mixed local codes, including out-of-range ones, with pseudo-random data.
    nxt = '1;
    for (int t = 0; t < TIN_N; t++) setf(t, (t * 3) % 16);
    for (int f = 0; f < TOUT_N; f++) setf(TO_F + f, (f % 4 == 3) ? 48 + f : (f * 7) % 48);
    for (int f = 0; f < LUT_N; f++) setf(LU_F + f, (f % 5 == 4) ? 63 : (f * 11 + 3) % 48);
    for (int s = 0; s < SLICES; s++) setf(CK_F + s, (s == 7) ? 40 : (s * 13) % 40);
    load(1'b0);
    for (int r = 0; r < 40; r++) begin
      nbr = {$urandom, $urandom, $urandom, $urandom};
      sl = SLICES'($urandom);
      chk("R5 R6 R7 R8 mixed codes");
    end

    // Reload a different image and check the commit point.
    nxt = '1;
    for (int t = 0; t < TIN_N; t++) setf(t, 15 - (t % 16));
    route_tin_out();
    nbr = {$urandom, $urandom, $urandom, $urandom};
    load(1'b1);
    chk("R2 new image after commit");
    for (int r = 0; r < 20; r++) begin
      nbr = {$urandom, $urandom, $urandom, $urandom};
      chk("R3 R8 after reload");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule